// File: doc/BRIEF.md
# Decimal Counter with Selectable Output Code

This block is a synchronous decade counter. It holds one decimal digit from 0 to 9 and advances it by one on each enabled clock edge, upward or downward according to a direction input. It wraps at both ends. Internally the digit is kept in plain binary. A combinational encoder presents it on the output in one of five decimal codes: excess-3, the 2421 weighted code, 2-out-of-5, the 6 4 2 -1 weighted code, and a 7-bit biquinary form.

The code is chosen by a select input. The block captures that input once, on the first rising clock edge after reset is released, and ignores it after that. Until the capture takes place, the output shows the digit in plain binary. A terminal-count flag marks the digit at which the next enabled step wraps. Its purpose is to let the surrounding logic see the carry or borrow point. The output is 7 bits wide. Codes that need only 4 or 5 bits use the low bits and hold the upper bits at zero.

Top module: `decade_code_counter`

## Requirements
- R1: When enabled and counting up, the digit moves through 0,1,...,9 and then back to 0. It never holds a value above 9.
- R2: When enabled and counting down (dir_down=1), the digit decreases by one, and from 0 it goes to 9.
- R3: While en is low, the digit and the output do not change.
- R4: An asynchronous reset (rst_n low) sets the digit to 0. Until the first rising edge after release, code_out shows plain binary, which is 7'b0000000 for digit 0.
- R5: code_sel is captured on the first rising edge after reset release, and later changes to it have no effect. The encodings are 0 = excess-3, 1 = 2421, 2 = 2-out-of-5, 3 = 6 4 2 -1, 4 = biquinary, and 5 to 7 = plain binary in code_out[3:0].
- R6: In excess-3, code_out[3:0] equals the digit plus 3, so 0 shows as 0011 and 9 as 1100.
- R7: In 2421, digits 0 to 4 show as their binary value and digits 5 to 9 show as the value plus 6 (5 = 1011, 9 = 1111).
- R8: In 2-out-of-5, code_out[4:0] for digits 0 through 9 is 11000, 00011, 00101, 00110, 01001, 01010, 01100, 10001, 10010, 10100. Exactly two bits are set.
- R9: In 6 4 2 -1, code_out[3:0] for digits 0 through 9 is 0000, 0011, 0010, 0101, 0100, 0111, 1000, 1011, 1010, 1101. For each of these, 6·b3 + 4·b2 + 2·b1 − b0 equals the digit.
- R10: In biquinary, bit 6 means "five" and bit 5 means "zero", and exactly one of the two is set. Bits 4:0 are one-hot, with bit k set for digit mod 5 equal to k.
- R11: term is high exactly when en is high and the digit is 9 while counting up, or the digit is 0 while counting down.
- R12: In the 4-bit codes (excess-3, 2421, 6 4 2 -1, binary), code_out[6:4] is zero. In 2-out-of-5, code_out[6:5] is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Count enable |
| dir_down | input | 1 | 1 = count down, 0 = count up |
| code_sel | input | 3 | Output code choice, captured once after reset |
| code_out | output | 7 | Current digit in the selected code |
| term | output | 1 | Terminal count, gated by en |

## Verification
A wrong digit register shows up on code_out at the first negative edge after the faulty step. A wrong wrap also shows on term one step earlier, because term anticipates the digit at which the count turns over. A code latch that captured the wrong value, or that took a later change of code_sel, changes the output format at once. That is visible as soon as the digit's pattern differs between the two codes. The bench compares both outputs against a behavioural model on every cycle, for each code, in both directions and with enable gaps.

// File: rtl/dcc_pkg.sv
package dcc_pkg;
  localparam int DIGIT_W = 4;
  localparam int OUT_W   = 7;
  localparam int SEL_W   = 3;
  localparam logic [DIGIT_W-1:0] LAST_DIGIT = 4'd9;
  localparam int GROUP   = 5;

  typedef enum logic [SEL_W-1:0] {
    CODE_XS3  = 3'd0,
    CODE_2421 = 3'd1,
    CODE_2OF5 = 3'd2,
    CODE_NEG1 = 3'd3,
    CODE_BIQ  = 3'd4,
    CODE_BIN  = 3'd5
  } code_e;

  function automatic code_e decode_sel(input logic [SEL_W-1:0] raw);
    case (raw)
      3'd0:    return CODE_XS3;
      3'd1:    return CODE_2421;
      3'd2:    return CODE_2OF5;
      3'd3:    return CODE_NEG1;
      3'd4:    return CODE_BIQ;
      default: return CODE_BIN;
    endcase
  endfunction

  function automatic logic [OUT_W-1:0] enc_xs3(input logic [DIGIT_W-1:0] d);
    logic [DIGIT_W-1:0] v;
    v = d + 4'd3;
    return {{(OUT_W-DIGIT_W){1'b0}}, v};
  endfunction

  function automatic logic [OUT_W-1:0] enc_2421(input logic [DIGIT_W-1:0] d);
    logic [DIGIT_W-1:0] v;
    v = (d < 4'd5) ? d : d + 4'd6;
    return {{(OUT_W-DIGIT_W){1'b0}}, v};
  endfunction

  function automatic logic [OUT_W-1:0] enc_2of5(input logic [DIGIT_W-1:0] d);
    logic [4:0] v;
    case (d)
      4'd0:    v = 5'b11000;
      4'd1:    v = 5'b00011;
      4'd2:    v = 5'b00101;
      4'd3:    v = 5'b00110;
      4'd4:    v = 5'b01001;
      4'd5:    v = 5'b01010;
      4'd6:    v = 5'b01100;
      4'd7:    v = 5'b10001;
      4'd8:    v = 5'b10010;
      default: v = 5'b10100;
    endcase
    return {{(OUT_W-5){1'b0}}, v};
  endfunction

  function automatic logic [OUT_W-1:0] enc_neg1(input logic [DIGIT_W-1:0] d);
    logic [DIGIT_W-1:0] v;
    case (d)
      4'd0:    v = 4'b0000;
      4'd1:    v = 4'b0011;
      4'd2:    v = 4'b0010;
      4'd3:    v = 4'b0101;
      4'd4:    v = 4'b0100;
      4'd5:    v = 4'b0111;
      4'd6:    v = 4'b1000;
      4'd7:    v = 4'b1011;
      4'd8:    v = 4'b1010;
      default: v = 4'b1101;
    endcase
    return {{(OUT_W-DIGIT_W){1'b0}}, v};
  endfunction

  function automatic logic [OUT_W-1:0] enc_biq(input logic [DIGIT_W-1:0] d);
    logic               high;
    logic [DIGIT_W-1:0] rem;
    logic [GROUP-1:0]   ones;
    high = (d >= 4'd5);
    rem  = high ? d - 4'd5 : d;
    ones = '0;
    for (int k = 0; k < GROUP; k++) begin
      ones[k] = (rem == DIGIT_W'(k));
    end
    return {high, ~high, ones};
  endfunction

  function automatic logic [OUT_W-1:0] enc_bin(input logic [DIGIT_W-1:0] d);
    return {{(OUT_W-DIGIT_W){1'b0}}, d};
  endfunction
endpackage

// File: rtl/dcc_sel_capture.sv
module dcc_sel_capture
  import dcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] code_sel_i,
  output code_e            sel_o,
  output logic             pending_o
);
  code_e sel_q;
  logic  pending_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= CODE_BIN;
      pending_q <= 1'b1;
    end else if (pending_q) begin
      sel_q     <= decode_sel(code_sel_i);
      pending_q <= 1'b0;
    end
  end

  assign sel_o     = sel_q;
  assign pending_o = pending_q;

  AST_SEL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    !pending_q |=> ($stable(sel_q) && !pending_q)); // R5
  AST_SEL_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    pending_q |=> (sel_q == decode_sel($past(code_sel_i)))); // R5
endmodule

// File: rtl/dcc_digit.sv
module dcc_digit
  import dcc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               down,
  output logic [DIGIT_W-1:0] digit_o,
  output logic               at_end_o
);
  logic [DIGIT_W-1:0] digit_q;
  logic [DIGIT_W-1:0] digit_nx;
  logic               at_top;
  logic               at_bottom;

  assign at_top    = (digit_q == LAST_DIGIT);
  assign at_bottom = (digit_q == '0);
  assign at_end_o  = down ? at_bottom : at_top;

  always_comb begin
    digit_nx = digit_q;
    if (en) begin
      if (down) digit_nx = at_bottom ? LAST_DIGIT : digit_q - 4'd1;
      else      digit_nx = at_top ? '0 : digit_q + 4'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) digit_q <= '0;
    else        digit_q <= digit_nx;
  end

  assign digit_o = digit_q;

  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    digit_q <= LAST_DIGIT); // R1
  AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !down && digit_q == LAST_DIGIT) |=> (digit_q == '0)); // R1
  AST_UP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !down && digit_q != LAST_DIGIT) |=> (digit_q == DIGIT_W'($past(digit_q) + 4'd1))); // R1
  AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (en && down && digit_q == '0) |=> (digit_q == LAST_DIGIT)); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(digit_q)); // R3
endmodule

// File: rtl/dcc_encoder.sv
module dcc_encoder
  import dcc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  code_e              sel,
  input  logic [DIGIT_W-1:0] digit,
  output logic [OUT_W-1:0]   code_o
);
  always_comb begin
    case (sel)
      CODE_XS3:  code_o = enc_xs3(digit);
      CODE_2421: code_o = enc_2421(digit);
      CODE_2OF5: code_o = enc_2of5(digit);
      CODE_NEG1: code_o = enc_neg1(digit);
      CODE_BIQ:  code_o = enc_biq(digit);
      default:   code_o = enc_bin(digit);
    endcase
  end

  AST_TWO_HOT: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == CODE_2OF5) |-> ($countones(code_o) == 2 && code_o[6:5] == 2'b00)); // R8
  AST_BIQ_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == CODE_BIQ) |-> ($countones(code_o[6:5]) == 1 && $countones(code_o[4:0]) == 1)); // R10
  AST_NARROW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == CODE_XS3 || sel == CODE_2421 || sel == CODE_NEG1 || sel == CODE_BIN)
      |-> (code_o[6:4] == 3'b000)); // R12
endmodule

// File: rtl/decade_code_counter.sv
module decade_code_counter
  import dcc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             dir_down,
  input  logic [SEL_W-1:0] code_sel,
  output logic [OUT_W-1:0] code_out,
  output logic             term
);
  code_e              sel;
  logic               sel_pending;
  logic [DIGIT_W-1:0] digit;
  logic               at_end;

  dcc_sel_capture u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_sel_i (code_sel),
    .sel_o      (sel),
    .pending_o  (sel_pending)
  );

  dcc_digit u_digit (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en),
    .down     (dir_down),
    .digit_o  (digit),
    .at_end_o (at_end)
  );

  dcc_encoder u_enc (
    .clk    (clk),
    .rst_n  (rst_n),
    .sel    (sel),
    .digit  (digit),
    .code_o (code_out)
  );

  assign term = en & at_end;

  AST_TERM_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !term); // R11
  AST_TERM_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (term && !dir_down) |=> (digit == '0)); // R11
  AST_PENDING_BIN: assert property (@(posedge clk) disable iff (!rst_n)
    sel_pending |-> (code_out[6:4] == 3'b000 && code_out[3:0] == digit)); // R4
endmodule

// File: tb/decade_code_counter_test.sv
`timescale 1ns/1ps
module decade_code_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       dir_down = 1'b0;
  logic [2:0] code_sel = 3'd0;
  logic [6:0] code_out;
  logic       term;

  int  checks = 0;
  int  errors = 0;
  int  m_digit = 0;
  int  m_sel = 5;
  bit  m_pending = 1'b1;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  decade_code_counter uut (
    .clk(clk), .rst_n(rst_n), .en(en), .dir_down(dir_down),
    .code_sel(code_sel), .code_out(code_out), .term(term)
  );

  function automatic logic [6:0] model_code(input int sel, input int d);
    logic [4:0] tbl5 [10] = '{5'b11000, 5'b00011, 5'b00101, 5'b00110, 5'b01001,
                             5'b01010, 5'b01100, 5'b10001, 5'b10010, 5'b10100};
    logic [3:0] tneg [10] = '{4'h0, 4'h3, 4'h2, 4'h5, 4'h4, 4'h7, 4'h8, 4'hB, 4'hA, 4'hD};
    int v;
    case (sel)
      0: v = d + 3;
      1: v = (d >= 5) ? d + 6 : d;
      2: v = int'(tbl5[d]);
      3: v = int'(tneg[d]);
      4: v = ((d >= 5) ? 64 : 32) + (1 << (d % 5));
      default: v = d;
    endcase
    return 7'(v);
  endfunction

  function automatic string tag_of(input int sel);
    case (sel)
      0: return "R6";
      1: return "R7";
      2: return "R8";
      3: return "R9";
      4: return "R10";
      default: return "R5";
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d digit=%0d sel=%0d", req, act, exp, m_digit, m_sel);
    end
  endtask

  task automatic check_outputs();
    int w;
    check(tag_of(m_sel), int'(code_out), int'(model_code(m_sel, m_digit)));
    if (m_sel != 2 && m_sel != 4) check("R12", int'(code_out[6:4]), 0);
    if (m_sel == 3) begin
      w = 6*code_out[3] + 4*code_out[2] + 2*code_out[1] - int'(code_out[0]);
      check("R9", w, m_digit);
    end
  endtask

  task automatic do_reset(input int sel);
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0; code_sel = 3'(sel);
    #1;
    m_digit = 0; m_sel = 5; m_pending = 1'b1;
    check("R4", int'(code_out), 0);
    check("R11", int'(term), 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R4", int'(code_out), 0);
  endtask

  task automatic cyc(input bit e, input bit dn);
    int prev;
    bit exp_term;
    en = e; dir_down = dn;
    #1;
    exp_term = e && (dn ? (m_digit == 0) : (m_digit == 9));
    check("R11", int'(term), int'(exp_term));
    prev = m_digit;
    @(posedge clk);
    #1;
    if (m_pending) begin
      m_sel = (code_sel > 3'd4) ? 5 : int'(code_sel);
      m_pending = 1'b0;
    end
    if (e) m_digit = dn ? (m_digit + 9) % 10 : (m_digit + 1) % 10;
    @(negedge clk);
    check_outputs();
    if (e && !dn && prev == 9) check("R1", int'(code_out), int'(model_code(m_sel, 0)));
    if (e && dn && prev == 0) check("R2", int'(code_out), int'(model_code(m_sel, 9)));
    if (!e) check("R3", int'(code_out), int'(model_code(m_sel, prev)));
  endtask

  initial begin
    for (int s = 0; s < 8; s++) begin
      do_reset(s);
      for (int i = 0; i < 24; i++) begin
        cyc((i % 7) != 3, 1'b0);
        if (i == 5) code_sel = 3'((s + 3) % 8);
      end
      for (int i = 0; i < 24; i++) cyc((i % 5) != 2, 1'b1);
      for (int i = 0; i < 8; i++) cyc(i[0], i[1]);
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule